// File: doc/BRIEF.md
# Pulse Width Meter

This block reports how long a single-bit digital input stays high, measured in clock cycles. The input is brought into the clock domain through a chain of synchronising flip-flops. Edges are then found on the synchronised level. Every rising edge restarts an internal tally. Every falling edge copies the tally of the high interval that just ended to the result bus, and pulses a one-cycle strobe at the same time.

The result is not a live counter. It holds the most recent completed high time, unchanged, until the next falling edge replaces it. The time the input spends low has no influence on the result. Very long pulses are clamped at the largest value the result bus can carry.

The meter starts from a clean state after reset. If the input is already high when reset is released, that partial pulse is not measured. Measurement only begins with the first rising edge seen after the input has been low.

Top module: `pulse_width_meter`

## Requirements
- R1: While reset is asserted and in the cycle after its release, `width_o` is zero and `width_valid_o` is low.
- R2: The input passes through `SYNC_STAGES` (at least 2, default 2) flip-flops before edge detection. A high pulse sampled high at H consecutive rising clock edges is reported as the value H.
- R3: Each rising edge restarts the tally, so a result never depends on earlier pulses.
- R4: `width_valid_o` is high for exactly one clock cycle per completed pulse. It is high in the cycle that follows the (`SYNC_STAGES`+1)-th rising clock edge, counting from the first edge at which the input is sampled low. `width_o` carries the new value in that same cycle.
- R5: A pulse longer than 2^`CNT_W`-1 cycles is reported as 2^`CNT_W`-1 (all ones); the tally does not wrap.
- R6: Between two published results, `width_o` keeps its value, including while a new pulse is being measured.
- R7: A pulse already high when reset is released is ignored: its falling edge produces no strobe and leaves `width_o` at zero.
- R8: Only the high time is reported. Low gaps of any length, including a single cycle between two pulses, do not change the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on its rising edge |
| rst_ni | input | 1 | Synchronous reset, active low |
| pulse_i | input | 1 | Signal whose high time is measured; may be asynchronous |
| width_o | output | CNT_W | Most recent completed high time, in clock cycles |
| width_valid_o | output | 1 | One-cycle strobe marking a newly published width |

## Verification
Some properties are checked on every cycle by the bound assertions. They cover the single-cycle strobe, that a strobe follows a high-to-low change of the synchronised level, that the output holds between strobes, that a restart loads one, and that the tally holds at all ones. Other behaviour can only be shown by the bench's scenarios at the ports: the exact value reported for each pulse length, the strobe latency relative to the raw input, clamping past the counter limit, independence from the low gap, and the ignored partial pulse after reset. The bench sweeps every pulse length around a small counter limit to cover these.

// File: rtl/pulse_width_meter_pkg.sv
package pulse_width_meter_pkg;

    // Classification of one cycle of the synchronised level.
    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2
    } edge_kind_e;

    // Classify the transition from the previous level to the current one.
    function automatic edge_kind_e classify_edge(input logic prev_lvl, input logic cur_lvl);
        edge_kind_e kind;
        kind = EDGE_NONE;
        if (cur_lvl && !prev_lvl) begin
            kind = EDGE_RISE;
        end else if (!cur_lvl && prev_lvl) begin
            kind = EDGE_FALL;
        end
        return kind;
    endfunction

endpackage

// File: rtl/pulse_width_meter_sync.sv
module pulse_width_meter_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_LVL = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic din_i,
    output logic dout_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_state_t;

    sync_state_t state_d;
    sync_state_t state_q;

    generate
        if (STAGES < 2) begin : g_bad_depth
            initial begin
                $error("pulse_width_meter_sync: STAGES must be at least 2");
            end
        end
    endgenerate

    always_comb begin
        state_d       = state_q;
        state_d.chain = {state_q.chain[STAGES-2:0], din_i};
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q.chain <= {STAGES{RESET_LVL}};
        end else begin
            state_q <= state_d;
        end
    end

    assign dout_o = state_q.chain[STAGES-1];

endmodule

// File: rtl/pulse_width_meter_edge.sv
module pulse_width_meter_edge
    import pulse_width_meter_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic level_i,
    output logic start_o,
    output logic capture_o
);

    typedef struct packed {
        logic prev;
        logic armed;
    } edge_state_t;

    edge_state_t state_d;
    edge_state_t state_q;
    edge_kind_e  kind;

    always_comb begin
        kind      = classify_edge(state_q.prev, level_i);
        state_d   = state_q;
        start_o   = 1'b0;
        capture_o = 1'b0;
        state_d.prev = level_i;
        case (kind)
            EDGE_RISE: begin
                start_o       = 1'b1;
                state_d.armed = 1'b1;
            end
            EDGE_FALL: begin
                // Only a pulse whose start was seen is published.
                capture_o = state_q.armed;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            // Previous level starts high: a level already high at release is no edge.
            state_q.prev  <= 1'b1;
            state_q.armed <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/pulse_width_meter_count.sv
module pulse_width_meter_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             level_i,
    output logic [CNT_W-1:0] count_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] tally;
    } count_state_t;

    count_state_t state_d;
    count_state_t state_q;

    always_comb begin
        state_d = state_q;
        if (start_i) begin
            // The cycle of the rising edge is the first high cycle.
            state_d.tally = CNT_ONE;
        end else if (level_i && (state_q.tally != CNT_MAX)) begin
            state_d.tally = state_q.tally + CNT_ONE;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q.tally <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign count_o = state_q.tally;

endmodule

// File: rtl/pulse_width_meter_hold.sv
module pulse_width_meter_hold #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             capture_i,
    input  logic [CNT_W-1:0] count_i,
    output logic [CNT_W-1:0] width_o,
    output logic             valid_o
);

    typedef struct packed {
        logic [CNT_W-1:0] width;
        logic             valid;
    } hold_state_t;

    hold_state_t state_d;
    hold_state_t state_q;

    always_comb begin
        state_d       = state_q;
        state_d.valid = capture_i;
        if (capture_i) begin
            state_d.width = count_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q.width <= '0;
            state_q.valid <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign width_o = state_q.width;
    assign valid_o = state_q.valid;

endmodule

// File: rtl/pulse_width_meter.sv
module pulse_width_meter #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             pulse_i,
    output logic [CNT_W-1:0] width_o,
    output logic             width_valid_o
);

    logic             sync_lvl;
    logic             start;
    logic             capture;
    logic [CNT_W-1:0] tally;

    pulse_width_meter_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_LVL (1'b1)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .din_i  (pulse_i),
        .dout_o (sync_lvl)
    );

    pulse_width_meter_edge u_edge (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .level_i   (sync_lvl),
        .start_o   (start),
        .capture_o (capture)
    );

    pulse_width_meter_count #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (start),
        .level_i (sync_lvl),
        .count_o (tally)
    );

    pulse_width_meter_hold #(
        .CNT_W (CNT_W)
    ) u_hold (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .capture_i (capture),
        .count_i   (tally),
        .width_o   (width_o),
        .valid_o   (width_valid_o)
    );

endmodule

// File: rtl/pulse_width_meter_chk.sv
module pulse_width_meter_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             sync_lvl,
    input logic             start,
    input logic [CNT_W-1:0] tally,
    input logic [CNT_W-1:0] width_o,
    input logic             width_valid_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    // R4: the strobe never lasts two cycles.
    assert_valid_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        width_valid_o |=> !width_valid_o);

    // R4: a strobe follows a high-to-low change of the synchronised level.
    assert_valid_after_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        width_valid_o |-> (!$past(sync_lvl) && $past(sync_lvl, 2)));

    // R6: without a strobe the published width does not move.
    assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !width_valid_o |-> (width_o == $past(width_o)));

    // R3: a rising edge restarts the tally at one.
    assert_restart_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start |=> (tally == CNT_ONE));

    // R5: a full tally stays full while the level stays high.
    assert_no_overflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tally == CNT_MAX && sync_lvl && !start) |=> (tally == CNT_MAX));

endmodule

bind pulse_width_meter pulse_width_meter_chk #(
    .CNT_W (CNT_W)
) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .sync_lvl      (sync_lvl),
    .start         (start),
    .tally         (tally),
    .width_o       (width_o),
    .width_valid_o (width_valid_o)
);

// File: tb/pulse_width_meter_tb.sv
`timescale 1ns/1ps
module pulse_width_meter_tb;

    localparam int CNT_W   = 4;
    localparam int STAGES  = 2;
    localparam int MAXV    = (1 << CNT_W) - 1;
    localparam int LATENCY = STAGES + 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pulse = 1'b0;
    logic [CNT_W-1:0] width;
    logic             valid;

    int n_checks = 0;
    int n_fails  = 0;
    int vcount   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    pulse_width_meter #(
        .CNT_W       (CNT_W),
        .SYNC_STAGES (STAGES)
    ) u_dut (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .pulse_i       (pulse),
        .width_o       (width),
        .width_valid_o (valid)
    );

    // Strobe counter, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && valid) vcount <= vcount + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int expect_w(input int h);
        return (h > MAXV) ? MAXV : h;
    endfunction

    // Called just after a negedge. High for h edges, then low for l edges (l >= LATENCY+1).
    // Checks the strobe position (R4) and the published value (R2/R5).
    task automatic pulse_and_check(input int h, input int l);
        int v0;
        bit pos_ok;
        v0 = vcount;
        pos_ok = 1'b1;
        pulse = 1'b1;
        repeat (h) @(negedge clk);
        pulse = 1'b0;
        for (int i = 1; i <= l; i++) begin
            @(negedge clk);
            if (valid != (i == LATENCY)) pos_ok = 1'b0;
            if (i == LATENCY) begin
                check(width == expect_w(h), (h > MAXV) ? "R5" : "R2", width, expect_w(h));
            end
        end
        check(pos_ok, "R4 strobe position", pos_ok, 1);
        check(vcount == v0 + 1, "R4 strobe count", vcount - v0, 1);
    endtask

    initial begin
        int v0;
        bit stable;

        // R1: reset state, with the input held high through reset.
        pulse = 1'b1;
        repeat (4) @(negedge clk);
        check(width == 0, "R1 width in reset", width, 0);
        check(valid == 1'b0, "R1 valid in reset", valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(width == 0, "R1 width after release", width, 0);

        // R7: partial pulse at release is ignored.
        repeat (8) @(negedge clk);
        pulse = 1'b0;
        repeat (6) @(negedge clk);
        check(vcount == 0, "R7 no strobe", vcount, 0);
        check(width == 0, "R7 width", width, 0);

        // R2/R5/R4: sweep every length around the counter limit.
        for (int h = 1; h <= MAXV + 5; h++) begin
            pulse_and_check(h, 4 + (h % 3));
        end

        // R3: a short pulse after a saturated one reports only itself.
        pulse_and_check(MAXV + 7, 5);
        pulse_and_check(3, 5);

        // R8/R3: single- and few-cycle gaps between pulses.
        for (int gap = 1; gap <= 3; gap++) begin
            for (int h2 = 1; h2 <= 6; h2 += 5) begin
                v0 = vcount;
                pulse = 1'b1;
                repeat (7) @(negedge clk);
                pulse = 1'b0;
                repeat (gap) @(negedge clk);
                pulse = 1'b1;
                repeat (h2) @(negedge clk);
                pulse = 1'b0;
                repeat (6) @(negedge clk);
                check(width == h2, "R8 second width", width, h2);
                check(vcount == v0 + 2, "R8 strobe count", vcount - v0, 2);
            end
        end

        // R6: value held while a new pulse is measured and while idle.
        pulse_and_check(6, 5);
        stable = 1'b1;
        pulse = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (width != 6) stable = 1'b0;
        end
        check(stable, "R6 held during high", width, 6);
        pulse = 1'b0;
        repeat (LATENCY) @(negedge clk);
        check(width == 12, "R6 replaced at fall", width, 12);
        stable = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (width != 12) stable = 1'b0;
        end
        check(stable, "R6 held while idle", width, 12);

        // R1: reset mid-run clears the result, then measurement resumes.
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(width == 0, "R1 width after mid-run reset", width, 0);
        check(valid == 1'b0, "R1 valid after mid-run reset", valid, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        pulse_and_check(9, 5);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule